// File: doc/BRIEF.md
# Latch-Addressed Legacy Register Front End

This block is the bus-facing front end of the legacy personality of a dual-personality floppy controller. It has no directly decoded registers. Each bus access, read or write, uses part of its address to set or clear one of eight internal latch bits. The current latch state then picks which of eight legacy registers the access reaches.

Reads return a fixed code. The all-ones register gives 0xFF and every other register gives 0x00. Writes that reach the mode register feed an unlock detector that watches one data bit. When that bit follows a fixed four-step pattern, the block pulses a request to change to the enhanced register set and raises a mode flag. A clear input lets the enhanced side return the front end to its idle state when it switches back.

Top module: `legacy_latch_front`

## Requirements
- R1: The register index is `addr_i >> 9`, and address bits below bit 9 have no effect. On every read or write, index bits 3..1 pick a latch from 0 to 7 and index bit 0 is the value written into it.
- R2: The selected register number is {latch7, latch6, latch4}, with latch7 in bit 2 and latch4 in bit 0. The other latches do not affect the selection.
- R3: On a read, `rdata_o` takes 0xFF if the selected register is 0 and 0x00 otherwise. The value appears one cycle after `rd_i` and is held until the next read.
- R4: The latch update of an access takes effect before that same access selects its register.
- R5: Only writes whose selected register is 6 feed the unlock detector, which samples `wdata_i[6]`. Reads and writes to any other register leave it unchanged.
- R6: The detector advances on the bit sequence 1, 0, 1, 1. A value that does not match the expected bit holds the current step and does not reset it.
- R7: When the fourth step matches, `switch_o` is high for exactly the one cycle after that write, `mode_flag_o` becomes 1 and the step count returns to 0.
- R8: `clr_i` zeroes all eight latches, the step count and `mode_flag_o` on the next edge. A bus access in the same cycle as `clr_i` is ignored.
- R9: After reset, all latches and the step count are 0, and `rdata_o`, `switch_o` and `mode_flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Return to idle: clears latches, step count and mode flag |
| addr_i | input | 13 | Bus byte address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| switch_o | output | 1 | One-cycle request to change to the enhanced register set |
| mode_flag_o | output | 1 | Set when the unlock pattern completes |

## Verification
Some properties are checked by assertions on every cycle:
- the read data is only ever 0x00 or 0xFF, and it holds between reads;
- a clear empties the latches and the step count;
- a non-matching write or an idle cycle leaves the step unchanged;
- each switch pulse lasts one cycle, follows a write, and comes with the mode flag set and the step back at zero.

Other behaviours can only be shown by the bench's scenarios, because they depend on sequences of accesses:
- that the latch address mapping and the {7,6,4} register selection are correct;
- that the latch update and the read happen in the same access;
- that writes to registers other than 6 are ignored;
- that the pattern with interleaved mismatches still unlocks;
- that a clear in the middle of the pattern restarts it.

// File: rtl/legacy_fe_pkg.sv
package legacy_fe_pkg;
  localparam int unsigned LATCH_N   = 8;
  localparam int unsigned IDX_W     = $clog2(LATCH_N) + 1;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned REG_ALL1  = 0;
  localparam int unsigned REG_MODE  = 6;

  // register number = {latch7, latch6, latch4}
  function automatic logic [SEL_W-1:0] reg_sel(input logic [LATCH_N-1:0] l);
    return {l[7], l[6], l[4]};
  endfunction
endpackage

// File: rtl/lfe_latch_bank.sv
module lfe_latch_bank
  import legacy_fe_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               acc_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [LATCH_N-1:0] latch_nxt_o
);
  logic [LATCH_N-1:0] latch_q;

  for (genvar g = 0; g < LATCH_N; g++) begin : g_latch
    logic hit;
    assign hit = acc_i && (idx_i[IDX_W-1:1] == g);
    assign latch_nxt_o[g] = hit ? idx_i[0] : latch_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= '0;
    else if (clr_i)  latch_q <= '0;
    else             latch_q <= latch_nxt_o;
  end

  a_r8_clr_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (latch_q == '0));
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !clr_i) |=> $stable(latch_q));
endmodule

// File: rtl/lfe_unlock_seq.sv
module lfe_unlock_seq #(
  parameter int unsigned       LEN     = 4,
  parameter logic [LEN-1:0]    PATTERN = 4'b1101  // element k at bit k: 1,0,1,1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic feed_i,
  input  logic bit_i,
  output logic fire_o
);
  localparam int unsigned STEP_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic              match;

  assign match = feed_i && (bit_i == PATTERN[step_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      fire_o <= 1'b0;
    end else if (clr_i) begin
      step_q <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= match && (step_q == LAST);
      if (match) step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
    end
  end

  a_r6_mismatch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !match) |=> $stable(step_q));
  a_r8_clr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (step_q == '0 && !fire_o));
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  a_r7_step_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (step_q == '0));
endmodule

// File: rtl/legacy_latch_front.sv
module legacy_latch_front
  import legacy_fe_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned REG_SHIFT = 9,
  parameter int unsigned MODE_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              switch_o,
  output logic              mode_flag_o
);
  logic [IDX_W-1:0]   idx;
  logic               acc;
  logic [LATCH_N-1:0] latch_nxt;
  logic [SEL_W-1:0]   sel;
  logic               feed;
  logic               unused_bits;

  assign idx  = addr_i[REG_SHIFT +: IDX_W];
  assign acc  = (rd_i || wr_i) && !clr_i;
  assign unused_bits = ^{addr_i[REG_SHIFT-1:0], addr_i[ADDR_W-1:REG_SHIFT+IDX_W],
                         wdata_i[DATA_W-1:MODE_BIT+1], wdata_i[MODE_BIT-1:0]};

  lfe_latch_bank u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .acc_i       (acc),
    .idx_i       (idx),
    .latch_nxt_o (latch_nxt)
  );

  // selection uses post-update latches of this access
  assign sel  = reg_sel(latch_nxt);
  assign feed = wr_i && !clr_i && (sel == SEL_W'(REG_MODE));

  lfe_unlock_seq #(.LEN(4), .PATTERN(4'b1101)) u_unlock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .feed_i (feed),
    .bit_i  (wdata_i[MODE_BIT]),
    .fire_o (switch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdata_o <= '0;
    else if (rd_i && !clr_i)      rdata_o <= (sel == SEL_W'(REG_ALL1)) ? '1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_flag_o <= 1'b0;
    else if (clr_i)    mode_flag_o <= 1'b0;
    else if (switch_o) mode_flag_o <= 1'b1;
  end

  a_r3_rdata_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o == '0) || (rdata_o == '1));
  a_r3_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || clr_i) |=> $stable(rdata_o));
  a_r5_switch_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> $past(wr_i && !clr_i));
  a_r7_flag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (switch_o && !clr_i) |=> mode_flag_o);
endmodule

// File: tb/legacy_latch_front_tb.sv
module legacy_latch_front_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       switch_o, mode_flag_o;
  int checks = 0, fails = 0;

  always #10 clk_i = ~clk_i;

  legacy_latch_front dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; outputs sampled at the following negedge
  task automatic acc(input int idx, input bit rd, input bit wr, input logic [7:0] d,
                     input logic [8:0] low = 9'h000, input bit clr = 1'b0);
    @(negedge clk_i);
    addr_i = {idx[3:0], low}; rd_i = rd; wr_i = wr; wdata_i = d; clr_i = clr;
    @(negedge clk_i);
    rd_i = 0; wr_i = 0; clr_i = 0;
  endtask

  task automatic do_clr();
    acc(0, 0, 0, 8'h00, 9'h000, 1'b1);
  endtask

  // reads only: L6=1, L7=1, L4=0 -> register 6
  task automatic goto_mode();
    acc(13, 1, 0, 0); acc(15, 1, 0, 0); acc(8, 1, 0, 0);
  endtask

  task automatic mode_wr(input bit b, input bit exp_sw, input string req);
    acc(15, 0, 1, b ? 8'h40 : 8'hBF);
    chk(req, {7'd0, switch_o}, {7'd0, exp_sw});
  endtask

  task automatic t_reset();
    chk("R9 rdata", rdata_o, 8'h00);
    chk("R9 switch", {7'd0, switch_o}, 8'h00);
    chk("R9 flag", {7'd0, mode_flag_o}, 8'h00);
    acc(0, 1, 0, 0);
    chk("R9 latches zero -> reg0", rdata_o, 8'hFF);
  endtask

  task automatic t_read_select();
    acc(9, 1, 0, 0);  chk("R4 set L4 in same read", rdata_o, 8'h00);
    acc(0, 1, 0, 0);  chk("R3 hold / other latch", rdata_o, 8'h00);
    acc(8, 1, 0, 0);  chk("R4 clear L4 in same read", rdata_o, 8'hFF);
    acc(13, 0, 1, 0); acc(0, 1, 0, 0); chk("R2 L6 selects", rdata_o, 8'h00);
    acc(12, 1, 0, 0); chk("R2 L6 cleared", rdata_o, 8'hFF);
    acc(15, 1, 0, 0); chk("R2 L7 selects", rdata_o, 8'h00);
    acc(14, 1, 0, 0); chk("R2 L7 cleared", rdata_o, 8'hFF);
    acc(3, 1, 0, 0); acc(5, 1, 0, 0); acc(11, 1, 0, 0);
    chk("R2 latches 1,2,5 no effect", rdata_o, 8'hFF);
    acc(9, 1, 0, 0, 9'h1FF); chk("R1 low address bits ignored", rdata_o, 8'h00);
    acc(8, 1, 0, 0, 9'h155); chk("R1 low bits ignored clear", rdata_o, 8'hFF);
    acc(9, 0, 0, 0); chk("R3 no strobe no change", rdata_o, 8'hFF);
    acc(2, 1, 0, 0); acc(3, 1, 0, 0); acc(0, 1, 0, 0);
  endtask

  task automatic t_other_reg();
    acc(13, 1, 0, 0); acc(9, 1, 0, 0); // reg 3
    acc(13, 0, 1, 8'h40); acc(13, 0, 1, 8'h00); acc(13, 0, 1, 8'h40);
    acc(13, 0, 1, 8'h40);
    chk("R5 reg3 writes ignored", {7'd0, switch_o}, 8'h00);
    chk("R5 flag unchanged", {7'd0, mode_flag_o}, 8'h00);
    acc(8, 1, 0, 0); acc(15, 1, 0, 0); // reg 6
    mode_wr(1, 0, "R5 step1"); mode_wr(0, 0, "R5 step2");
    mode_wr(1, 0, "R5 step3"); mode_wr(1, 1, "R7 pulse on 4th");
    @(negedge clk_i);
    chk("R7 single pulse", {7'd0, switch_o}, 8'h00);
    chk("R7 flag set", {7'd0, mode_flag_o}, 8'h01);
  endtask

  task automatic t_mismatch();
    do_clr();
    chk("R8 flag cleared", {7'd0, mode_flag_o}, 8'h00);
    goto_mode();
    mode_wr(0, 0, "R6 mismatch at step0");
    mode_wr(1, 0, "R6 s0"); mode_wr(1, 0, "R6 hold s1");
    mode_wr(0, 0, "R6 s1"); mode_wr(0, 0, "R6 hold s2");
    mode_wr(1, 0, "R6 s2"); mode_wr(0, 0, "R6 hold s3");
    acc(15, 1, 0, 0); // reads do not feed
    mode_wr(1, 1, "R6 complete after holds");
    mode_wr(1, 0, "R7 restart s0"); mode_wr(0, 0, "R7 s1");
    mode_wr(1, 0, "R7 s2"); mode_wr(1, 1, "R7 second unlock");
  endtask

  task automatic t_clear();
    do_clr(); goto_mode();
    mode_wr(1, 0, "R8 s0"); mode_wr(0, 0, "R8 s1"); mode_wr(1, 0, "R8 s2");
    do_clr();
    acc(0, 1, 0, 0); chk("R8 latches cleared", rdata_o, 8'hFF);
    goto_mode();
    mode_wr(1, 0, "R8 step reset"); mode_wr(0, 0, "R8 s1b");
    mode_wr(1, 0, "R8 s2b"); mode_wr(1, 1, "R8 full seq after clear");
    acc(13, 1, 0, 0, 9'h000, 1'b1);
    acc(0, 1, 0, 0); chk("R8 access during clear ignored", rdata_o, 8'hFF);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_read_select();
    t_other_reg();
    t_mismatch();
    t_clear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule